// File: doc/BRIEF.md
# Macro Call Parameter Dispatcher

This block sits on the method-write path of a command processor and watches for writes that land in the macro call window of the method space. Inside the window, the method number carries two things: which macro is meant, and whether the write starts that macro or supplies one more argument for it. An even method starts macro `n` and carries its first argument. The odd method just above it queues an additional argument.

The start request waits in a single holding slot until the macro executor reports idle. The block then issues a one-cycle start pulse together with the macro number and the first argument, which the executor loads into its register R1. The executor takes further arguments on demand through a read strobe, so a macro can consume as many or as few arguments as it needs. Arguments that the previous macro left unread are discarded at the moment the next macro starts. Arguments written after the start write are kept, in order, for the new macro.

An empty queue either stalls the reader or reports an underflow, depending on whether more writes can still arrive for the running macro. A queue overflow, or a second start while one is already waiting, sets a sticky fault.

Top module: `macro_param_dispatch`

## Requirements
- R1: After reset, `macro_go`, `fault`, `param_ack` and `param_underflow` are all 0 and the argument queue is empty. `fault` returns to 0 only through reset.
- R2: A write to method `BASE_MTHD + 2n` (default base 0xE00, n from 0 to `NUM_MACROS-1`) with `exec_idle` high gives `macro_go` high for one cycle, two clock edges after the write is sampled. In that cycle `macro_idx` equals n and `macro_arg0` equals the write data.
- R3: While `exec_idle` is low, a start request waits and no `macro_go` is produced. `macro_go` rises on the first edge at which `exec_idle` is sampled high.
- R4: A write to method `BASE_MTHD + 2n + 1` appends its data to the argument queue. When `param_rd` is high and an argument is available, `param_ack` is high in the same cycle and `param_data` shows the oldest queued argument, which is removed at the next edge. Arguments come out in write order. The n of an append write is not checked.
- R5: Method writes outside the window `BASE_MTHD` to `BASE_MTHD + 2*NUM_MACROS - 1` neither start a macro nor queue an argument.
- R6: When a macro starts, every argument queued before its start write and not yet read is discarded. The first read after the start returns the first argument appended after the start write.
- R7: While a start is waiting, reads may take only the arguments queued before that start write. Once those are used up, a read gives `param_underflow` and no `param_ack`, even if later arguments are queued.
- R8: A read that finds no argument available while `feed_pending` is high and no start is waiting stalls. Both `param_ack` and `param_underflow` stay low, and the read is acknowledged in the cycle after the next append write is sampled.
- R9: A read that finds no argument available while `feed_pending` is low gives `param_underflow` high in the same cycle, with `param_ack` low.
- R10: An append write that finds the queue holding `QDEPTH` arguments, with no read in the same cycle, is dropped and sets `fault`. The `QDEPTH` arguments already queued are unchanged.
- R11: A start write that arrives while another start is still waiting is dropped and sets `fault`. The waiting start goes ahead unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mthd_valid | input | 1 | Method write strobe |
| mthd_addr | input | MAW (12) | Method number of the write |
| mthd_data | input | DW (32) | Method write data |
| exec_idle | input | 1 | Executor is free to start a macro |
| feed_pending | input | 1 | More method writes may still arrive |
| param_rd | input | 1 | Executor requests the next argument |
| param_ack | output | 1 | Argument delivered this cycle |
| param_data | output | DW (32) | Argument being delivered |
| param_underflow | output | 1 | Read found no argument and none can arrive |
| macro_go | output | 1 | One-cycle macro start pulse |
| macro_idx | output | IW (6) | Index of the macro being started |
| macro_arg0 | output | DW (32) | First argument, destined for R1 |
| fault | output | 1 | Sticky overflow or start-collision flag |

## Verification
The read-side results are combinational. `param_ack`, `param_data` and `param_underflow` are due in the same cycle that `param_rd` is raised, so the bench samples them at the falling edge of that cycle and releases the strobe after the next rising edge. A start write passes through two registers: the holding slot and then the output stage. Its pulse is therefore due two edges after the write is sampled, or one edge after `exec_idle` is raised when the start has been waiting. The start driver enters the expected cycle number in the scoreboard along with the index and argument, and the monitor compares all three. Append writes take effect one edge after they are sampled, and the stall case checks that the acknowledge appears only after that edge.

// File: rtl/mpd_pkg.sv
// Package: shared types for the macro parameter dispatcher.
// Assumes nothing beyond being compiled before the modules that import it.
package mpd_pkg;

    // Decoded meaning of one method write.
    typedef enum logic [1:0] {
        MK_NONE  = 2'd0,
        MK_START = 2'd1,
        MK_PUSH  = 2'd2
    } mkind_t;

endpackage

// File: rtl/mpd_decode.sv
// Method decoder: classifies a method write as macro start, argument
// append or unrelated, and extracts the macro index.
// Assumes NUM_MACROS >= 2 and that the window fits inside the method space.
module mpd_decode
    import mpd_pkg::*;
#(
    parameter int MAW = 12,
    parameter logic [MAW-1:0] BASE_MTHD = 12'hE00,
    parameter int NUM_MACROS = 64,
    localparam int IW = $clog2(NUM_MACROS),
    localparam int SPAN = 2 * NUM_MACROS
) (
    input  logic           valid,
    input  logic [MAW-1:0] addr,
    output mkind_t         kind,
    output logic [IW-1:0]  idx
);

    logic [MAW-1:0] off;
    logic           hit;

    // Offset into the window, in-window test and kind selection.
    always_comb begin
        off  = addr - BASE_MTHD;
        hit  = valid && (addr >= BASE_MTHD) && (off < MAW'(SPAN));
        idx  = off[IW:1];
        if (!hit)
            kind = MK_NONE;
        else if (off[0])
            kind = MK_PUSH;
        else
            kind = MK_START;
    end

endmodule

// File: rtl/mpd_fifo.sv
// Argument queue: circular buffer with a combinational head and a bulk
// discard that drops a given number of entries from the head in one cycle.
// Assumes DEPTH is a power of two, that the caller never writes when full
// unless it also reads, and that read and discard are never issued together.
module mpd_fifo #(
    parameter int DW = 32,
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          drop,
    input  logic [CW-1:0] drop_n,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);

    logic [DW-1:0] slot [DEPTH];
    logic [PW-1:0] rptr;
    logic [PW-1:0] wptr;
    logic [CW-1:0] gone;

    // Number of entries leaving the head this cycle.
    always_comb begin
        gone = drop ? drop_n : CW'(rd);
        head = slot[rptr];
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            rptr  <= rptr + PW'(gone);
            if (wr)
                wptr <= wptr + PW'(1);
            count <= count + CW'(wr) - gone;
        end
    end

    // Storage: one register per entry, written at the tail pointer.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr && wptr == PW'(g))
                slot[g] <= wdata;
        end
    end

endmodule

// File: rtl/mpd_ctl.sv
// Launch and read control: holds one waiting start, tracks how many queued
// arguments belong to the macro before it, issues the start pulse when the
// executor is idle, answers argument reads and raises the sticky fault.
// Assumes the executor does not read arguments while it reports idle.
module mpd_ctl
    import mpd_pkg::*;
#(
    parameter int DW = 32,
    parameter int DEPTH = 16,
    parameter int IW = 6,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mkind_t        kind,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] data,
    input  logic          exec_idle,
    input  logic          feed_pending,
    input  logic          param_rd,
    input  logic [CW-1:0] count,
    output logic          q_wr,
    output logic          q_rd,
    output logic          q_drop,
    output logic [CW-1:0] q_drop_n,
    output logic          param_ack,
    output logic          param_underflow,
    output logic          macro_go,
    output logic [IW-1:0] macro_idx,
    output logic [DW-1:0] macro_arg0,
    output logic          fault
);

    logic          waiting;
    logic [IW-1:0] wait_idx;
    logic [DW-1:0] wait_arg;
    logic [CW-1:0] stale;
    logic          launch;
    logic [CW-1:0] avail;
    logic          full;
    logic          take_start;
    logic          collide;
    logic          overflow;

    // Decisions for this cycle: launch, read answer, queue write, faults.
    always_comb begin
        launch          = waiting && exec_idle;
        avail           = waiting ? stale : count;
        param_ack       = param_rd && !launch && (avail != '0);
        param_underflow = param_rd && !launch && (avail == '0)
                          && (waiting || !feed_pending);
        full            = (count == CW'(DEPTH));
        q_wr            = (kind == MK_PUSH) && (!full || param_ack);
        overflow        = (kind == MK_PUSH) && full && !param_ack;
        take_start      = (kind == MK_START) && (!waiting || launch);
        collide         = (kind == MK_START) && waiting && !launch;
        q_rd            = param_ack;
        q_drop          = launch;
        q_drop_n        = stale;
    end

    // Holding slot for one start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting  <= 1'b0;
            wait_idx <= '0;
            wait_arg <= '0;
        end else if (take_start) begin
            waiting  <= 1'b1;
            wait_idx <= idx;
            wait_arg <= data;
        end else if (launch) begin
            waiting  <= 1'b0;
        end
    end

    // Count of queued arguments that precede the waiting start write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stale <= '0;
        else if (take_start)
            stale <= count - CW'(param_ack) - (launch ? stale : '0);
        else if (launch)
            stale <= '0;
        else if (waiting)
            stale <= stale - CW'(param_ack);
    end

    // Start pulse and the values handed to the executor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            macro_go   <= 1'b0;
            macro_idx  <= '0;
            macro_arg0 <= '0;
        end else begin
            macro_go <= launch;
            if (launch) begin
                macro_idx  <= wait_idx;
                macro_arg0 <= wait_arg;
            end
        end
    end

    // Sticky fault on dropped append or dropped start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault <= 1'b0;
        else if (overflow || collide)
            fault <= 1'b1;
    end

endmodule

// File: rtl/macro_param_dispatch.sv
// Top: macro call parameter dispatcher. Decodes method writes in the macro
// window, queues appended arguments and launches macros with their first
// argument when the executor is idle.
// Assumes QDEPTH is a power of two and NUM_MACROS >= 2.
module macro_param_dispatch
    import mpd_pkg::*;
#(
    parameter int MAW = 12,
    parameter logic [MAW-1:0] BASE_MTHD = 12'hE00,
    parameter int NUM_MACROS = 64,
    parameter int DW = 32,
    parameter int QDEPTH = 16,
    localparam int IW = $clog2(NUM_MACROS),
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mthd_valid,
    input  logic [MAW-1:0] mthd_addr,
    input  logic [DW-1:0]  mthd_data,
    input  logic           exec_idle,
    input  logic           feed_pending,
    input  logic           param_rd,
    output logic           param_ack,
    output logic [DW-1:0]  param_data,
    output logic           param_underflow,
    output logic           macro_go,
    output logic [IW-1:0]  macro_idx,
    output logic [DW-1:0]  macro_arg0,
    output logic           fault
);

    mkind_t        kind;
    logic [IW-1:0] dec_idx;
    logic          q_wr;
    logic          q_rd;
    logic          q_drop;
    logic [CW-1:0] q_drop_n;
    logic [CW-1:0] q_count;

    mpd_decode #(
        .MAW        (MAW),
        .BASE_MTHD  (BASE_MTHD),
        .NUM_MACROS (NUM_MACROS)
    ) u_decode (
        .valid (mthd_valid),
        .addr  (mthd_addr),
        .kind  (kind),
        .idx   (dec_idx)
    );

    mpd_fifo #(
        .DW    (DW),
        .DEPTH (QDEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (q_wr),
        .wdata  (mthd_data),
        .rd     (q_rd),
        .drop   (q_drop),
        .drop_n (q_drop_n),
        .head   (param_data),
        .count  (q_count)
    );

    mpd_ctl #(
        .DW    (DW),
        .DEPTH (QDEPTH),
        .IW    (IW)
    ) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .kind            (kind),
        .idx             (dec_idx),
        .data            (mthd_data),
        .exec_idle       (exec_idle),
        .feed_pending    (feed_pending),
        .param_rd        (param_rd),
        .count           (q_count),
        .q_wr            (q_wr),
        .q_rd            (q_rd),
        .q_drop          (q_drop),
        .q_drop_n        (q_drop_n),
        .param_ack       (param_ack),
        .param_underflow (param_underflow),
        .macro_go        (macro_go),
        .macro_idx       (macro_idx),
        .macro_arg0      (macro_arg0),
        .fault           (fault)
    );

endmodule

// File: rtl/mpd_chk.sv
// Checker: temporal properties of the dispatcher's ports, bound to the top.
// Assumes the synchronous active-low reset of the top module.
module mpd_chk (
    input logic clk,
    input logic rst_n,
    input logic exec_idle,
    input logic param_rd,
    input logic param_ack,
    input logic param_underflow,
    input logic macro_go,
    input logic fault
);

    // A start pulse follows a cycle in which the executor was idle (R3).
    a_r3_go_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        macro_go |-> $past(exec_idle));

    // An argument is delivered only on request (R4).
    a_r4_ack_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        param_ack |-> param_rd);

    // Delivery and underflow never coincide (R9).
    a_r9_ack_or_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(param_ack && param_underflow));

    // Underflow is reported only for a read (R9).
    a_r9_underflow_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        param_underflow |-> param_rd);

    // Fault stays set until reset (R10).
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

endmodule

bind macro_param_dispatch mpd_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .exec_idle       (exec_idle),
    .param_rd        (param_rd),
    .param_ack       (param_ack),
    .param_underflow (param_underflow),
    .macro_go        (macro_go),
    .fault           (fault)
);

// File: tb/macro_param_dispatch_test.sv
// Bench: scoreboard of expected macro starts plus directed argument reads.
module macro_param_dispatch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mthd_valid = 1'b0;
    logic [11:0] mthd_addr = '0;
    logic [31:0] mthd_data = '0;
    logic        exec_idle = 1'b0;
    logic        feed_pending = 1'b0;
    logic        param_rd = 1'b0;
    logic        param_ack;
    logic [31:0] param_data;
    logic        param_underflow;
    logic        macro_go;
    logic [5:0]  macro_idx;
    logic [31:0] macro_arg0;
    logic        fault;

    int    checks = 0;
    int    fails = 0;
    longint cyc = 0;

    typedef struct {
        int          idx;
        logic [31:0] arg;
        longint      at;
    } go_t;
    go_t sbq[$];

    macro_param_dispatch uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .mthd_valid      (mthd_valid),
        .mthd_addr       (mthd_addr),
        .mthd_data       (mthd_data),
        .exec_idle       (exec_idle),
        .feed_pending    (feed_pending),
        .param_rd        (param_rd),
        .param_ack       (param_ack),
        .param_data      (param_data),
        .param_underflow (param_underflow),
        .macro_go        (macro_go),
        .macro_idx       (macro_idx),
        .macro_arg0      (macro_arg0),
        .fault           (fault)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: every start pulse is compared with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && macro_go) begin
            if (sbq.size() == 0) begin
                check("R5", "unexpected start idx", 64'(macro_idx), 64'hFFFF);
            end else begin
                go_t e;
                e = sbq.pop_front();
                check("R2", "start idx", 64'(macro_idx), 64'(e.idx));
                check("R2", "start arg0", 64'(macro_arg0), 64'(e.arg));
                check("R3", "start cycle", 64'(cyc), 64'(e.at));
            end
        end
    end

    task automatic wr_mthd(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        mthd_valid = 1'b1; mthd_addr = a; mthd_data = d;
        @(posedge clk); #1;
        mthd_valid = 1'b0;
    endtask

    // Start write while the executor is idle: pulse due two edges later.
    task automatic start_now(input int n, input logic [31:0] d);
        @(posedge clk); #1;
        sbq.push_back('{n, d, cyc + 2});
        mthd_valid = 1'b1; mthd_addr = 12'hE00 + 12'(2 * n); mthd_data = d;
        @(posedge clk); #1;
        mthd_valid = 1'b0;
        @(posedge clk); #1;
        exec_idle = 1'b0;
    endtask

    // Raise idle for a waiting start: pulse due on the next edge.
    task automatic release_idle(input int n, input logic [31:0] d);
        @(posedge clk); #1;
        sbq.push_back('{n, d, cyc + 1});
        exec_idle = 1'b1;
        @(posedge clk); #1;
        exec_idle = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic eack,
                           input logic [31:0] ed, input logic euf);
        @(posedge clk); #1;
        param_rd = 1'b1;
        @(negedge clk);
        check(req, "ack", 64'(param_ack), 64'(eack));
        check(req, "underflow", 64'(param_underflow), 64'(euf));
        if (eack) check(req, "data", 64'(param_data), 64'(ed));
        @(posedge clk); #1;
        param_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "go after reset", 64'(macro_go), 64'd0);
        check("R1", "fault after reset", 64'(fault), 64'd0);
        check("R1", "ack after reset", 64'(param_ack), 64'd0);
        check("R1", "underflow after reset", 64'(param_underflow), 64'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // R5: writes outside the window are ignored.
        exec_idle = 1'b1;
        wr_mthd(12'hE80, 32'h11);
        wr_mthd(12'hD00, 32'h22);
        wr_mthd(12'hE81, 32'h33);
        exec_idle = 1'b0;
        pop_chk("R5", 1'b0, 32'h0, 1'b1);

        // R2: start macro 5 with idle executor.
        exec_idle = 1'b1;
        start_now(5, 32'hA5A5_0005);

        // R4: three appends read back in order.
        wr_mthd(12'hE0B, 32'h0000_0101);
        wr_mthd(12'hE0B, 32'h0000_0102);
        wr_mthd(12'hE0B, 32'h0000_0103);
        pop_chk("R4", 1'b1, 32'h0000_0101, 1'b0);
        pop_chk("R4", 1'b1, 32'h0000_0102, 1'b0);
        pop_chk("R4", 1'b1, 32'h0000_0103, 1'b0);

        // R9: empty with no feed pending.
        pop_chk("R9", 1'b0, 32'h0, 1'b1);

        // R8: empty with feed pending stalls until the append lands.
        feed_pending = 1'b1;
        @(posedge clk); #1;
        param_rd = 1'b1;
        @(negedge clk);
        check("R8", "stall ack", 64'(param_ack), 64'd0);
        check("R8", "stall underflow", 64'(param_underflow), 64'd0);
        @(posedge clk); #1;
        mthd_valid = 1'b1; mthd_addr = 12'hE0B; mthd_data = 32'h0000_0808;
        @(negedge clk);
        check("R8", "ack before capture", 64'(param_ack), 64'd0);
        @(posedge clk); #1;
        mthd_valid = 1'b0;
        @(negedge clk);
        check("R8", "ack after capture", 64'(param_ack), 64'd1);
        check("R8", "data after capture", 64'(param_data), 64'h0808);
        @(posedge clk); #1;
        param_rd = 1'b0;

        // R7 and R3: start 9 waits; only earlier arguments readable.
        wr_mthd(12'hE0B, 32'h0000_0901);
        wr_mthd(12'hE12, 32'h5555_0009);
        wr_mthd(12'hE13, 32'h0000_0902);
        pop_chk("R7", 1'b1, 32'h0000_0901, 1'b0);
        pop_chk("R7", 1'b0, 32'h0, 1'b1);
        repeat (3) @(posedge clk);
        release_idle(9, 32'h5555_0009);
        pop_chk("R6", 1'b1, 32'h0000_0902, 1'b0);
        feed_pending = 1'b0;
        pop_chk("R9", 1'b0, 32'h0, 1'b1);

        // R6 and R11: leftovers flushed; colliding start dropped.
        wr_mthd(12'hE13, 32'h0000_0C01);
        wr_mthd(12'hE13, 32'h0000_0C02);
        wr_mthd(12'hE18, 32'h7777_000C);
        wr_mthd(12'hE19, 32'h0000_0C10);
        @(negedge clk);
        check("R11", "fault before collision", 64'(fault), 64'd0);
        wr_mthd(12'hE28, 32'h9999_0014);
        @(negedge clk);
        check("R11", "fault after collision", 64'(fault), 64'd1);
        release_idle(12, 32'h7777_000C);
        repeat (3) @(posedge clk);
        pop_chk("R6", 1'b1, 32'h0000_0C10, 1'b0);
        pop_chk("R6", 1'b0, 32'h0, 1'b1);

        // R10: overflow drops the extra append and sets the fault.
        do_reset();
        for (int i = 0; i < 17; i++)
            wr_mthd(12'hE01, 32'h0000_1000 + 32'(i));
        @(negedge clk);
        check("R10", "fault after overflow", 64'(fault), 64'd1);
        for (int i = 0; i < 16; i++)
            pop_chk("R10", 1'b1, 32'h0000_1000 + 32'(i), 1'b0);
        pop_chk("R10", 1'b0, 32'h0, 1'b1);
        @(negedge clk);
        check("R10", "fault held", 64'(fault), 64'd1);

        repeat (4) @(posedge clk);
        check("R2", "all starts seen", 64'(sbq.size()), 64'd0);
        summary();
        $finish;
    end

endmodule